// File: doc/BRIEF.md
# Configuration Security and Signature Controller

This block sits between a request source and a device's configuration memory. It passes configuration read-back (verify) and register preload requests through to the memory side only while a one-bit security flag is clear. Once the flag is programmed, both kinds of request are refused from the very next request onward. A 64-bit user signature, held as eight bytes, stays readable and writable at all times, whatever the state of the flag.

Each request is one cycle wide: a 3-bit operation code, an address and a write byte. Every request other than the idle code returns a response one cycle later. The response carries a valid strobe, a deny flag and a data byte. The only way to clear the security flag is a full erase request, which also tells the memory side to wipe the configuration contents. The memory cells and the logic array are outside this block.

Top module: `cfgsec_ctrl`

## Requirements
- R1: After reset, `secure` is 0, `rsp_valid`, `preload_en` and `erase_en` are 0, and all eight signature bytes read as 0.
- R2: Operation codes on `req_op` are: 0 idle, 1 verify, 2 preload, 3 set security, 4 signature read, 5 signature write, 6 full erase. A request with `req_valid` high and a non-idle code produces `rsp_valid` high for exactly the following cycle. An idle code produces no response.
- R3: A verify request while `secure` is 0 raises `cfg_rd_en` combinationally in the request cycle, with `cfg_addr` equal to `req_addr`. The next cycle returns the `cfg_rdata` value of that cycle on `rsp_data`, with `rsp_deny` low.
- R4: A verify request while `secure` is 1 keeps `cfg_rd_en` low. Its response has `rsp_deny` high for that one cycle and `rsp_data` all zero.
- R5: A preload request while `secure` is 0 pulses `preload_en` for one cycle, the cycle after the request, with `preload_addr` and `preload_data` equal to the request's address and write byte. Its response is not denied and carries zero data.
- R6: A preload request while `secure` is 1 leaves `preload_en` low and is answered with a deny and zero data.
- R7: A set-security request makes `secure` 1 from the next cycle on. A verify or preload request issued in the cycle straight after it is already refused.
- R8: A signature write stores `req_wdata` into the byte selected by `req_addr[2:0]`; the upper address bits are ignored. It is never denied, whatever the state of `secure`.
- R9: A signature read returns the byte selected by `req_addr[2:0]` and is never denied, whatever the state of `secure`.
- R10: A full erase request clears `secure` from the next cycle on, pulses `erase_en` for that one cycle, and leaves the signature bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_addr | input | CFG_AW | Configuration address; low bits pick a signature byte |
| req_wdata | input | DATA_W | Write byte for preload or signature write |
| cfg_rd_en | output | 1 | Configuration read enable toward the memory |
| cfg_addr | output | CFG_AW | Configuration read address |
| cfg_rdata | input | DATA_W | Configuration data returned in the same cycle |
| preload_en | output | 1 | Register preload strobe |
| preload_addr | output | CFG_AW | Preload target |
| preload_data | output | DATA_W | Preload value |
| erase_en | output | 1 | Full erase strobe |
| secure | output | 1 | Security flag |
| rsp_valid | output | 1 | Response strobe |
| rsp_deny | output | 1 | Request refused |
| rsp_data | output | DATA_W | Response data |

## Verification
The bench builds the block with its default parameters: 6 address bits, 8-bit data and 8 signature bytes. With these values the whole signature can be written and read back. Address values with upper bits set also reach the signature path, which shows that only the 3-bit index selects a byte. A behavioural reference model runs alongside the design. It goes through unsecured access, setting the flag, a refused verify and preload in the cycle right after setting, signature access under security, and an erase that restores access while the signature survives.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;
   typedef enum logic [2:0] {
      OP_IDLE    = 3'd0,
      OP_VERIFY  = 3'd1,
      OP_PRELOAD = 3'd2,
      OP_SECURE  = 3'd3,
      OP_SIG_RD  = 3'd4,
      OP_SIG_WR  = 3'd5,
      OP_ERASE   = 3'd6
   } cs_op_e;
endpackage

// File: rtl/cfgsec_gate.sv
module cfgsec_gate
   import cfgsec_pkg::*;
(
   input  logic       req_valid,
   input  logic [2:0] req_op,
   input  logic       secure,
   output logic       do_verify,
   output logic       do_preload,
   output logic       do_secure,
   output logic       do_sig_rd,
   output logic       do_sig_wr,
   output logic       do_erase,
   output logic       deny,
   output logic       any
);
   cs_op_e op;
   assign op = cs_op_e'(req_op);

   always_comb begin
      do_verify  = 1'b0;
      do_preload = 1'b0;
      do_secure  = 1'b0;
      do_sig_rd  = 1'b0;
      do_sig_wr  = 1'b0;
      do_erase   = 1'b0;
      deny       = 1'b0;
      any        = 1'b0;
      if (req_valid) begin
         any = (op != OP_IDLE);
         unique case (op)
            OP_VERIFY:  if (secure) deny = 1'b1; else do_verify  = 1'b1;
            OP_PRELOAD: if (secure) deny = 1'b1; else do_preload = 1'b1;
            OP_SECURE:  do_secure = 1'b1;
            OP_SIG_RD:  do_sig_rd = 1'b1;
            OP_SIG_WR:  do_sig_wr = 1'b1;
            OP_ERASE:   do_erase  = 1'b1;
            default:    ;
         endcase
      end
   end
endmodule

// File: rtl/cfgsec_sec_flag.sv
module cfgsec_sec_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic secure_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      secure_o <= 1'b0;
      else if (clr_i)  secure_o <= 1'b0;
      else if (set_i)  secure_o <= 1'b1;
   end

   assert_set_takes_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i && !clr_i |=> secure_o);
   assert_erase_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !secure_o);
endmodule

// File: rtl/cfgsec_sig_store.sv
module cfgsec_sig_store #(
   parameter int DATA_W    = 8,
   parameter int SIG_BYTES = 8,
   localparam int SIG_AW   = $clog2(SIG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SIG_AW-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SIG_AW-1:0] rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [SIG_BYTES-1:0][DATA_W-1:0] bytes_w;

   for (genvar g = 0; g < SIG_BYTES; g++) begin : g_byte
      logic [DATA_W-1:0] byte_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          byte_q <= '0;
         else if (wr_en && wr_idx == SIG_AW'(g)) byte_q <= wr_data;
      end
      assign bytes_w[g] = byte_q;
   end

   assign rd_data = bytes_w[rd_idx];

   assert_sig_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> bytes_w[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl
   import cfgsec_pkg::*;
#(
   parameter int CFG_AW    = 6,
   parameter int DATA_W    = 8,
   parameter int SIG_BYTES = 8,
   localparam int SIG_AW   = $clog2(SIG_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [CFG_AW-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              cfg_rd_en,
   output logic [CFG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_rdata,
   output logic              preload_en,
   output logic [CFG_AW-1:0] preload_addr,
   output logic [DATA_W-1:0] preload_data,
   output logic              erase_en,
   output logic              secure,
   output logic              rsp_valid,
   output logic              rsp_deny,
   output logic [DATA_W-1:0] rsp_data
);
   if (SIG_BYTES < 2 || (1 << SIG_AW) != SIG_BYTES) begin : g_chk_sig
      $error("SIG_BYTES must be a power of two of at least 2");
   end
   if (CFG_AW < SIG_AW) begin : g_chk_aw
      $error("CFG_AW must cover the signature index");
   end
   if (DATA_W < 1) begin : g_chk_dw
      $error("DATA_W must be positive");
   end

   logic do_verify, do_preload, do_secure, do_sig_rd, do_sig_wr, do_erase, deny, any;
   logic [DATA_W-1:0] sig_rd_data;
   logic [DATA_W-1:0] rsp_data_d;

   cfgsec_gate u_gate (
      .req_valid (req_valid),
      .req_op    (req_op),
      .secure    (secure),
      .do_verify (do_verify),
      .do_preload(do_preload),
      .do_secure (do_secure),
      .do_sig_rd (do_sig_rd),
      .do_sig_wr (do_sig_wr),
      .do_erase  (do_erase),
      .deny      (deny),
      .any       (any)
   );

   cfgsec_sec_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (do_secure),
      .clr_i   (do_erase),
      .secure_o(secure)
   );

   cfgsec_sig_store #(.DATA_W(DATA_W), .SIG_BYTES(SIG_BYTES)) u_sig (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (do_sig_wr),
      .wr_idx (req_addr[SIG_AW-1:0]),
      .wr_data(req_wdata),
      .rd_idx (req_addr[SIG_AW-1:0]),
      .rd_data(sig_rd_data)
   );

   assign cfg_rd_en = do_verify;
   assign cfg_addr  = req_addr;

   always_comb begin
      rsp_data_d = '0;
      if (do_verify)      rsp_data_d = cfg_rdata;
      else if (do_sig_rd) rsp_data_d = sig_rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_deny     <= 1'b0;
         rsp_data     <= '0;
         preload_en   <= 1'b0;
         preload_addr <= '0;
         preload_data <= '0;
         erase_en     <= 1'b0;
      end else begin
         rsp_valid  <= any;
         rsp_deny   <= deny;
         rsp_data   <= rsp_data_d;
         preload_en <= do_preload;
         erase_en   <= do_erase;
         if (do_preload) begin
            preload_addr <= req_addr;
            preload_data <= req_wdata;
         end
      end
   end

   assert_deny_gives_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_deny |-> rsp_valid && rsp_data == '0);
   assert_secure_verify_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == OP_VERIFY && secure |=> rsp_deny);
   assert_no_preload_when_secure_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == OP_PRELOAD && secure |=> !preload_en);
   assert_sig_read_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_op == OP_SIG_RD |=> rsp_valid && !rsp_deny);
   assert_one_cycle_response_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
endmodule

// File: tb/tb_cfgsec_ctrl.sv
`timescale 1ns/1ps
module tb_cfgsec_ctrl;
   localparam int CFG_AW = 6;
   localparam int DATA_W = 8;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, req_valid;
   logic [2:0] req_op;
   logic [CFG_AW-1:0] req_addr, cfg_addr, preload_addr;
   logic [DATA_W-1:0] req_wdata, cfg_rdata, preload_data, rsp_data;
   logic cfg_rd_en, preload_en, erase_en, secure, rsp_valid, rsp_deny;

   function automatic logic [7:0] mem_fn(logic [5:0] a);
      return {a[1:0], a} ^ 8'hC3;
   endfunction
   assign cfg_rdata = mem_fn(cfg_addr);

   cfgsec_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .cfg_rd_en(cfg_rd_en),
      .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .preload_en(preload_en),
      .preload_addr(preload_addr), .preload_data(preload_data),
      .erase_en(erase_en), .secure(secure), .rsp_valid(rsp_valid),
      .rsp_deny(rsp_deny), .rsp_data(rsp_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   logic       m_sec;
   logic [7:0] m_sig [8];

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(logic [2:0] op, logic [5:0] addr, logic [7:0] wd, string tag);
      bit ev, ed, epl, eer;
      logic [7:0] edat;
      req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
      #1;
      ev = (op != 3'd0); ed = 0; epl = 0; eer = 0; edat = '0;
      case (op)
         3'd1: if (m_sec) ed = 1; else edat = mem_fn(addr);
         3'd2: if (m_sec) ed = 1; else epl = 1;
         3'd3: m_sec = 1'b1;
         3'd4: edat = m_sig[addr[2:0]];
         3'd5: m_sig[addr[2:0]] = wd;
         3'd6: begin m_sec = 1'b0; eer = 1; end
         default: ;
      endcase
      chk(tag, "cfg_rd_en", 32'(cfg_rd_en), 32'(op == 3'd1 && !ed));
      if (cfg_rd_en) chk(tag, "cfg_addr", 32'(cfg_addr), 32'(addr));
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0; req_op = 3'd0;
      chk(tag, "rsp_valid", 32'(rsp_valid), 32'(ev));
      chk(tag, "rsp_deny", 32'(rsp_deny), 32'(ed));
      chk(tag, "rsp_data", 32'(rsp_data), 32'(edat));
      chk(tag, "preload_en", 32'(preload_en), 32'(epl));
      if (epl) begin
         chk(tag, "preload_addr", 32'(preload_addr), 32'(addr));
         chk(tag, "preload_data", 32'(preload_data), 32'(wd));
      end
      chk(tag, "erase_en", 32'(erase_en), 32'(eer));
      chk(tag, "secure", 32'(secure), 32'(m_sec));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
      m_sec = 1'b0;
      for (int i = 0; i < 8; i++) m_sig[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "secure", 32'(secure), 0);
      chk("R1", "rsp_valid", 32'(rsp_valid), 0);
      chk("R1", "preload_en", 32'(preload_en), 0);
      chk("R1", "erase_en", 32'(erase_en), 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) step(3'd4, 6'(i), 8'h00, "R1_sig_zero");
      step(3'd0, 6'h11, 8'h00, "R2_idle");
      for (int i = 0; i < 8; i++) step(3'd5, 6'(i), 8'(8'h31 * (i + 1)), "R8_write");
      step(3'd5, 6'h2B, 8'hA5, "R8_upper_bits");
      for (int i = 0; i < 8; i++) step(3'd4, 6'(i + 8), 8'h00, "R9_read");
      step(3'd1, 6'h00, 8'h00, "R3_verify");
      step(3'd1, 6'h3F, 8'h00, "R3_verify");
      step(3'd1, 6'h15, 8'h00, "R3_verify");
      step(3'd2, 6'h07, 8'h5C, "R5_preload");
      step(3'd2, 6'h30, 8'hE1, "R5_preload");
      step(3'd3, 6'h00, 8'h00, "R7_set");
      step(3'd1, 6'h15, 8'h00, "R7_R4_verify_next");
      step(3'd2, 6'h07, 8'h5C, "R6_preload_denied");
      step(3'd1, 6'h22, 8'h00, "R4_verify_denied");
      step(3'd0, 6'h00, 8'h00, "R2_idle_secure");
      step(3'd4, 6'h03, 8'h00, "R9_read_secure");
      step(3'd5, 6'h06, 8'h7E, "R8_write_secure");
      step(3'd4, 6'h06, 8'h00, "R9_read_secure");
      step(3'd3, 6'h00, 8'h00, "R7_set_again");
      step(3'd6, 6'h00, 8'h00, "R10_erase");
      step(3'd2, 6'h01, 8'h99, "R10_preload_after");
      step(3'd1, 6'h2A, 8'h00, "R10_verify_after");
      for (int i = 0; i < 8; i++) step(3'd4, 6'(i), 8'h00, "R10_sig_kept");
      step(3'd6, 6'h00, 8'h00, "R10_erase_unsecured");
      step(3'd0, 6'h00, 8'h00, "R2_idle_end");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule